// File: doc/BRIEF.md
# Shared ready/data serial output pin

This block drives the single output pin of a converter-style serial port. One pin serves two purposes. At the start of each conversion frame it signals that a result is ready. For the rest of the frame it shifts out that 24-bit result, most significant bit first, paced by a serial clock that the host supplies.

A one-cycle frame strobe marks each new result. On that strobe the block copies the result word into a holding register and starts the frame. The frame opens with a ready window, during which the pin is high. A data window follows, during which the pin carries result bits. After the data window the pin is low until the next strobe. The result uses two's complement coding: 7FFFFF hex is positive full scale, 000000 hex is zero and 800000 hex is negative full scale.

The host serial clock is asynchronous. It passes through a two-flop synchronizer, and its falling edges are detected in the system clock domain. The serial clock must run at no more than one quarter of the system clock rate.

Top module: `shared_rdy_dout`

## Requirements
- R1: After reset, and in the gap between the end of one frame and the next strobe, the pin is low.
- R2: A strobe sampled high at a clock edge starts a frame. From the cycle after that edge, the pin is high for READY_CYC cycles.
- R3: The data window starts READY_CYC cycles after the strobe edge and shows the MSB (bit 23) of the captured word. If no serial clock falls during the data window, the MSB stays on the pin for the whole window.
- R4: Each falling serial clock edge in the data window moves the pin on by one bit. After n falling edges (n < 24) the pin shows bit 23-n. The new bit appears within 3 system clock cycles of the falling edge.
- R5: After 24 or more falling edges in one data window, the pin stays low for the rest of that window.
- R6: The data window ends FRAME_CYC cycles after the strobe edge, and the pin then goes low.
- R7: A short read leaves the last bit on the pin until the window ends. The bit pointer restarts with each frame, so the first data bit of a new frame is the MSB of the new word whatever the earlier read did.
- R8: Serial clock falling edges outside the data window do not move the bit pointer.
- R9: The word is captured at the strobe. Later changes on the result input do not alter the bits shifted out in that frame.
- R10: A strobe that arrives during a frame restarts the frame at its ready window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock, asynchronous |
| frame_strb | input | 1 | One-cycle marker of a new conversion result |
| result | input | WORD_W | Conversion result, two's complement |
| dout_rdy | output | 1 | Shared ready/data pin |

## Verification
The pin is checked under four kinds of read. A full 24-clock read with extra clocks distinguishes correct bit order from the low-after-excess rule. A frame with no clocks shows that the MSB is held until the window closes. A five-clock short read shows that the last bit is held and that the pointer restarts in the next frame. Further cases cover clocks that fall during the ready window, a result input that changes in mid-read, and a strobe that arrives in mid-frame, which separates a correct word capture and frame restart from logic that follows the live input or lets the pointer run free.

// File: rtl/shared_rdy_dout.sv
module shared_rdy_dout #(
  parameter int WORD_W    = 24,
  parameter int READY_CYC = 6,
  parameter int FRAME_CYC = 384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              frame_strb,
  input  logic [WORD_W-1:0] result,
  output logic              dout_rdy
);
  localparam int CW = $clog2(FRAME_CYC);
  localparam int PW = $clog2(WORD_W + 1);
  localparam logic [PW-1:0] PTR_END  = PW'(WORD_W);
  localparam logic [PW-1:0] TOP_BIT  = PW'(WORD_W - 1);
  localparam logic [CW-1:0] RDY_LAST = CW'(READY_CYC);
  localparam logic [CW-1:0] FRM_LAST = CW'(FRAME_CYC - 1);

  logic              s1, s2, s3;
  logic              active;
  logic [CW-1:0]     cnt;
  logic [PW-1:0]     ptr;
  logic [WORD_W-1:0] hold;

  wire sfall     = s3 & ~s2;
  wire rdy_mode  = active && (cnt < RDY_LAST);
  wire data_mode = active && (cnt >= RDY_LAST);
  wire [PW-1:0] bit_idx = TOP_BIT - ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sclk;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      hold   <= '0;
    end else if (frame_strb) begin
      active <= 1'b1;
      cnt    <= '0;
      hold   <= result;
    end else if (active) begin
      if (cnt == FRM_LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (frame_strb || !data_mode)
      ptr <= '0;
    else if (sfall && ptr != PTR_END)
      ptr <= ptr + 1'b1;
  end

  assign dout_rdy = rdy_mode ? 1'b1 :
                    (data_mode && ptr != PTR_END) ? hold[bit_idx] : 1'b0;

  AST_PTR_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_mode) |-> ptr == '0);  // R7
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_mode && $past(data_mode)) |-> (ptr == $past(ptr) || ptr == $past(ptr) + 1'b1));  // R4
  AST_EXCESS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (data_mode && ptr == PTR_END) |-> !dout_rdy);  // R5
  AST_IDLE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_mode && $past(!data_mode)) |-> ptr == '0);  // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_strb) |-> $stable(hold));  // R9
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_strb) |-> dout_rdy);  // R2
endmodule

// File: tb/shared_rdy_dout_bench.sv
module shared_rdy_dout_bench;
  localparam int W = 24, RDY = 6, FRM = 384;
  logic clk = 0, rst_n = 0, sclk = 0, strb = 0;
  logic [W-1:0] result = '0;
  logic dout_rdy;
  int n_chk = 0, n_fail = 0, fc = 0;
  bit done = 0;
  bit    q_v[$];
  string q_r[$];
  event  chk_ev;

  always #10 clk = ~clk;

  shared_rdy_dout #(.WORD_W(W), .READY_CYC(RDY), .FRAME_CYC(FRM)) u_shared_rdy_dout (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .frame_strb(strb),
    .result(result), .dout_rdy(dout_rdy));

  always @(chk_ev) begin
    bit e; string r;
    e = q_v.pop_front();
    r = q_r.pop_front();
    n_chk++;
    if (dout_rdy !== e) begin
      n_fail++;
      $display("FAIL %s: fc=%0d pin=%b expected=%b", r, fc, dout_rdy, e);
    end
  end

  task automatic expect_pin(bit v, string r);
    q_v.push_back(v);
    q_r.push_back(r);
    -> chk_ev;
    #1;
  endtask

  task automatic tick();
    @(negedge clk);
    fc++;
  endtask

  task automatic start_frame(logic [W-1:0] w);
    @(negedge clk);
    result = w;
    strb = 1;
    @(negedge clk);
    strb = 0;
    fc = 0;
  endtask

  task automatic pulse();
    sclk = 1;
    repeat (4) tick();
    sclk = 0;
    repeat (4) tick();
  endtask

  task automatic go_to(int t);
    while (fc < t) tick();
  endtask

  logic [W-1:0] w;

  initial begin
    repeat (3) @(negedge clk);
    expect_pin(0, "R1 reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    expect_pin(0, "R1 idle before strobe");

    // full read plus excess
    w = 24'hA5C3F1;
    start_frame(w);
    expect_pin(1, "R2 ready first cycle");
    go_to(RDY - 1);
    expect_pin(1, "R2 ready last cycle");
    go_to(RDY);
    expect_pin(w[23], "R3 MSB at data start");
    for (int i = 0; i < W; i++) begin
      pulse();
      if (i < W - 1) expect_pin(w[22 - i], "R4 bit after fall");
      else           expect_pin(0, "R5 low after 24 falls");
    end
    pulse();
    expect_pin(0, "R5 low after excess falls");
    go_to(FRM - 1);
    expect_pin(0, "R5 low to window end");
    go_to(FRM);
    expect_pin(0, "R6 low after window");
    repeat (5) tick();
    expect_pin(0, "R1 low between frames");

    // no clocks: negative full scale
    start_frame(24'h800000);
    go_to(RDY);
    expect_pin(1, "R3 MSB of 800000");
    go_to(FRM - 1);
    expect_pin(1, "R3 MSB held to window end");
    go_to(FRM);
    expect_pin(0, "R6 window closes");

    // short read of positive full scale: bit 18 of 7FFFFF is 1
    w = 24'h7FFFFF;
    start_frame(w);
    go_to(RDY);
    expect_pin(0, "R3 MSB of 7FFFFF");
    repeat (5) pulse();
    expect_pin(w[18], "R4 after five falls");
    go_to(FRM - 1);
    expect_pin(w[18], "R7 last bit held");

    // new frame: pointer restarts; clock falling inside ready window ignored
    w = 24'h5A5A5A;
    sclk = 1;
    start_frame(w);
    tick();
    sclk = 0;
    go_to(RDY);
    expect_pin(w[23], "R7 R8 MSB after ready-window fall");
    // change input during read
    result = 24'hFFFFFF;
    pulse();
    expect_pin(w[22], "R9 captured word kept");
    pulse();
    expect_pin(w[21], "R9 captured word kept bit 21");

    // mid-frame strobe restarts
    start_frame(24'h000000);
    expect_pin(1, "R10 restart ready");
    go_to(RDY);
    expect_pin(0, "R10 restart MSB of zero");
    go_to(FRM);
    expect_pin(0, "R6 end after restart");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, pin=%b expected=finish", dout_rdy);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule